// File: doc/BRIEF.md
# Multi-core interrupt routing controller

The block collects 32 level-sensitive interrupt sources and gates them with a 32-bit enable register. It then steers every surviving source toward a set of cores and a set of per-core interrupt lines. There are 4 cores with 4 lines each, so the block drives 16 registered interrupt outputs. Output index `4*core + line` is high when two things hold at once: some active source is routed to that core, and some active source is routed to that line. The two need not be the same source.

Software configures and observes the block through a simple single-cycle request port. It gives byte access to one routing byte per source and 32-bit access to the status, enable, enable-set, enable-clear and per-core status words. Status is never latched: it always equals the current input levels ANDed with the enable register. Read data comes back in the cycle after the request.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset all routing bytes and the enable register are zero, and all 16 outputs are low.
- R2: A 32-bit read at offset 0x20 returns `irq_i & enable`, using the input levels of the request cycle.
- R3: A 32-bit write at 0x28 ORs the write data into the enable register. A 32-bit read at 0x24 returns the enable register.
- R4: A 32-bit write at 0x2C clears each enable bit that is set in the write data.
- R5: A byte access at offset s (0x00 to 0x1F) reads or writes the routing byte of source s. Bits 3:0 select cores 0 to 3. Bits 7:4 select lines 0 to 3. Reads return the byte in `rdata_o[7:0]` with the upper bits zero.
- R6: Output `4*c + l` is high exactly when some active source has core bit c set and some active source has line bit l set. The two may be different sources.
- R7: A 32-bit read at `0x40 + 8*c` (c = 0 to 3) returns the active sources whose core bit c is set. A read at `0x44 + 8*c` returns zero.
- R8: Only size code 0 (byte, routing offsets only) and size code 2 (word, address bits 1:0 zero) are legal. Any other access reads zero and changes no state. Size code 1 is never legal.
- R9: Writes to 0x20, 0x24, the per-core windows and unmapped offsets change nothing. Reads of 0x28 and 0x2C return zero.
- R10: Outputs reflect an input, enable or routing change at the next clock edge after the change is registered. Read data is valid in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 32 | Level-sensitive interrupt sources |
| req_i | input | 1 | Bus request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 2 | Access size: 0 byte, 1 half (illegal), 2 word |
| addr_i | input | 8 | Byte offset |
| wdata_i | input | 32 | Write data; byte writes use bits 7:0 |
| rdata_o | output | 32 | Read data, registered, zero after non-read cycles |
| irq_o | output | 16 | Routed interrupts, index 4*core + line |

## Verification
The assertions assume a request lasts exactly one cycle. They also assume `irq_i` is free of X whenever reset is released, because the output checks compare registered results against states sampled one edge earlier. The bench follows these assumptions. It drives every input at the falling edge, holds `req_i` for a single cycle, and keeps `irq_i` at a defined value from time zero. It sweeps all 32 routing bytes, a series of pseudo-random source and enable patterns, and every illegal size and alignment combination that the decoder separates.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_HALF = 2'd1,
    ACC_WORD = 2'd2
  } acc_size_e;
endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int N_CORE = 4,
  parameter int N_LINE = 4,
  parameter int AW     = 8,
  parameter int DW     = 32,
  localparam int RT_W  = N_CORE + N_LINE
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          req_i,
  input  logic                          we_i,
  input  logic [1:0]                    size_i,
  input  logic [AW-1:0]                 addr_i,
  input  logic [DW-1:0]                 wdata_i,
  input  logic [N_SRC-1:0]              act_i,
  input  logic [N_CORE-1:0][N_SRC-1:0]  core_st_i,
  output logic [N_SRC-1:0][RT_W-1:0]    route_o,
  output logic [N_SRC-1:0]              en_o,
  output logic [DW-1:0]                 rdata_o
);
  localparam int SW  = $clog2(N_SRC);
  localparam int CIW = (N_CORE > 1) ? $clog2(N_CORE) : 1;
  localparam logic [AW-1:0] A_STAT    = AW'(N_SRC);
  localparam logic [AW-1:0] A_EN      = AW'(N_SRC + 4);
  localparam logic [AW-1:0] A_SET     = AW'(N_SRC + 8);
  localparam logic [AW-1:0] A_CLR     = AW'(N_SRC + 12);
  localparam logic [AW-1:0] A_WIN     = AW'(64);
  localparam logic [AW-1:0] A_WIN_END = AW'(64 + 8 * N_CORE);

  logic [N_SRC-1:0][RT_W-1:0] route_q;
  logic [N_SRC-1:0]           en_q;
  logic [DW-1:0]              rd_c, rdata_q;
  logic                       byte_ok, word_ok, rt_hit, win_hit;
  logic [AW-1:0]              win_off;
  logic [CIW-1:0]             win_idx;

  assign byte_ok = (size_i == ACC_BYTE);
  assign word_ok = (size_i == ACC_WORD) && (addr_i[1:0] == 2'b00);
  assign rt_hit  = addr_i < A_STAT;
  assign win_off = addr_i - A_WIN;
  assign win_idx = win_off[3 +: CIW];
  assign win_hit = (addr_i >= A_WIN) && (addr_i < A_WIN_END) && !addr_i[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      route_q <= '0;
      en_q    <= '0;
    end else if (req_i && we_i) begin
      if (byte_ok && rt_hit)
        route_q[addr_i[SW-1:0]] <= wdata_i[RT_W-1:0];
      else if (word_ok && addr_i == A_SET)
        en_q <= en_q | wdata_i[N_SRC-1:0];
      else if (word_ok && addr_i == A_CLR)
        en_q <= en_q & ~wdata_i[N_SRC-1:0];
    end
  end

  always_comb begin
    rd_c = '0;
    if (byte_ok && rt_hit) rd_c = DW'(route_q[addr_i[SW-1:0]]);
    else if (word_ok) begin
      if (win_hit)                rd_c = DW'(core_st_i[win_idx]);
      else if (addr_i == A_STAT)  rd_c = DW'(act_i);
      else if (addr_i == A_EN)    rd_c = DW'(en_q);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rdata_q <= '0;
    else if (req_i && !we_i)    rdata_q <= rd_c;
    else                        rdata_q <= '0;
  end

  assign route_o = route_q;
  assign en_o    = en_q;
  assign rdata_o = rdata_q;

  AST_EN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && size_i == ACC_WORD && addr_i == A_SET)
    |=> en_o == ($past(en_o) | $past(wdata_i[N_SRC-1:0]))); // R3
  AST_EN_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && size_i == ACC_WORD && addr_i == A_CLR)
    |=> en_o == ($past(en_o) & ~$past(wdata_i[N_SRC-1:0]))); // R4
  AST_BAD_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && size_i != ACC_BYTE &&
     (size_i != ACC_WORD || addr_i[1:0] != 2'b00))
    |=> $stable(en_o) && $stable(route_o)); // R8
  AST_BAD_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && size_i != ACC_BYTE &&
     (size_i != ACC_WORD || addr_i[1:0] != 2'b00))
    |=> rdata_o == '0); // R8
endmodule

// File: rtl/irq_route_matrix.sv
module irq_route_matrix #(
  parameter int N_SRC  = 32,
  parameter int N_CORE = 4,
  parameter int N_LINE = 4,
  localparam int RT_W  = N_CORE + N_LINE,
  localparam int N_OUT = N_CORE * N_LINE
) (
  input  logic [N_SRC-1:0]              irq_i,
  input  logic [N_SRC-1:0]              en_i,
  input  logic [N_SRC-1:0][RT_W-1:0]    route_i,
  output logic [N_SRC-1:0]              act_o,
  output logic [N_CORE-1:0][N_SRC-1:0]  core_st_o,
  output logic [N_OUT-1:0]              out_o
);
  logic [N_LINE-1:0][N_SRC-1:0] line_st;
  logic [N_CORE-1:0]            core_any;
  logic [N_LINE-1:0]            line_any;

  assign act_o = irq_i & en_i;

  for (genvar c = 0; c < N_CORE; c++) begin : g_core
    for (genvar s = 0; s < N_SRC; s++) begin : g_src
      assign core_st_o[c][s] = act_o[s] & route_i[s][c];
    end
    assign core_any[c] = |core_st_o[c];
  end

  for (genvar l = 0; l < N_LINE; l++) begin : g_line
    for (genvar s = 0; s < N_SRC; s++) begin : g_src
      assign line_st[l][s] = act_o[s] & route_i[s][N_CORE + l];
    end
    assign line_any[l] = |line_st[l];
  end

  // core and line conditions are independent, not per source
  for (genvar c = 0; c < N_CORE; c++) begin : g_oc
    for (genvar l = 0; l < N_LINE; l++) begin : g_ol
      assign out_o[c*N_LINE + l] = core_any[c] & line_any[l];
    end
  end
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl #(
  parameter int N_SRC  = 32,
  parameter int N_CORE = 4,
  parameter int N_LINE = 4,
  parameter int AW     = 8,
  parameter int DW     = 32,
  localparam int RT_W  = N_CORE + N_LINE,
  localparam int N_OUT = N_CORE * N_LINE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] irq_i,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [1:0]       size_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic [N_OUT-1:0] irq_o
);
  logic [N_SRC-1:0][RT_W-1:0]   route;
  logic [N_SRC-1:0]             en, act;
  logic [N_CORE-1:0][N_SRC-1:0] core_st;
  logic [N_OUT-1:0]             out_c, out_q;

  irq_route_regs #(
    .N_SRC(N_SRC), .N_CORE(N_CORE), .N_LINE(N_LINE), .AW(AW), .DW(DW)
  ) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .size_i, .addr_i, .wdata_i,
    .act_i(act), .core_st_i(core_st), .route_o(route), .en_o(en),
    .rdata_o
  );

  irq_route_matrix #(
    .N_SRC(N_SRC), .N_CORE(N_CORE), .N_LINE(N_LINE)
  ) u_matrix (
    .irq_i, .en_i(en), .route_i(route),
    .act_o(act), .core_st_o(core_st), .out_o(out_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= '0;
    else         out_q <= out_c;
  end

  assign irq_o = out_q;

  AST_EN_ZERO_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en == '0) |=> (irq_o == '0)); // R1
  AST_NO_ROUTE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (route == '0) |=> (irq_o == '0)); // R6
  AST_OUT_NEEDS_CORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o[0 +: N_LINE] != '0) |-> ($past(core_st[0]) != '0)); // R6
endmodule

// File: tb/sim_irq_route_ctrl.sv
`timescale 1ns/1ps
module sim_irq_route_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] irq_i = '0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [1:0]  size_i = 2'd0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [15:0] irq_o;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic [7:0]  route_m [32];
  logic [31:0] en_m = '0;

  always #2.5 clk_i = ~clk_i;

  irq_route_ctrl u0 (.*);

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic bus_wr(logic [7:0] a, logic [1:0] sz, logic [31:0] d);
    req_i = 1; we_i = 1; addr_i = a; size_i = sz; wdata_i = d;
    @(negedge clk_i);
    req_i = 0; we_i = 0;
  endtask

  task automatic bus_rd(logic [7:0] a, logic [1:0] sz, output logic [31:0] d);
    req_i = 1; we_i = 0; addr_i = a; size_i = sz;
    @(negedge clk_i);
    req_i = 0;
    d = rdata_o;
  endtask

  function automatic logic [31:0] act_m();
    return irq_i & en_m;
  endfunction

  function automatic logic [31:0] win_m(int c);
    logic [31:0] w = '0;
    for (int s = 0; s < 32; s++) w[s] = act_m() [s] & route_m[s][c];
    return w;
  endfunction

  function automatic logic [15:0] out_m();
    logic [3:0] ca = '0, la = '0;
    logic [15:0] o;
    for (int s = 0; s < 32; s++)
      if (act_m() [s]) begin
        ca |= route_m[s][3:0];
        la |= route_m[s][7:4];
      end
    for (int c = 0; c < 4; c++)
      for (int l = 0; l < 4; l++) o[4*c+l] = ca[c] & la[l];
    return o;
  endfunction

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, x;
    for (int s = 0; s < 32; s++) route_m[s] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);

    // R1 reset state
    chk("R1 out", 32'(irq_o), 0);
    bus_rd(8'h24, 2'd2, d); chk("R1 enable", d, 0);
    for (int s = 0; s < 32; s += 7) begin
      bus_rd(8'(s), 2'd0, d); chk("R1 route", d, 0);
    end

    // R5 routing bytes
    for (int s = 0; s < 32; s++) begin
      route_m[s] = 8'((s * 29 + 7) & 255);
      bus_wr(8'(s), 2'd0, {24'hABCDEF, route_m[s]});
    end
    for (int s = 0; s < 32; s++) begin
      bus_rd(8'(s), 2'd0, d); chk("R5 route readback", d, 32'(route_m[s]));
    end

    // R3 / R4 enable
    bus_wr(8'h28, 2'd2, 32'h00FF00FF); en_m |= 32'h00FF00FF;
    bus_rd(8'h24, 2'd2, d); chk("R3 set", d, en_m);
    bus_wr(8'h28, 2'd2, 32'hF0000000); en_m |= 32'hF0000000;
    bus_rd(8'h24, 2'd2, d); chk("R3 set or", d, en_m);
    bus_wr(8'h2C, 2'd2, 32'h100F000F); en_m &= ~32'h100F000F;
    bus_rd(8'h24, 2'd2, d); chk("R4 clear", d, en_m);

    // sweep: R2 R6 R7 R10
    x = 32'h1234_5679;
    for (int p = 0; p < 24; p++) begin
      x ^= x << 13; x ^= x >> 17; x ^= x << 5;
      if (p % 6 == 5) begin
        bus_wr(8'h28, 2'd2, x ^ 32'h5A5A5A5A); en_m |= x ^ 32'h5A5A5A5A;
        bus_wr(8'h2C, 2'd2, x & 32'h0F0F0F0F); en_m &= ~(x & 32'h0F0F0F0F);
      end
      irq_i = (p % 4 == 0) ? (x & 32'h0000_0101) : x;
      @(negedge clk_i);
      chk("R6 R10 outputs", 32'(irq_o), 32'(out_m()));
      bus_rd(8'h20, 2'd2, d); chk("R2 status", d, act_m());
      for (int c = 0; c < 4; c++) begin
        bus_rd(8'(8'h40 + 8 * c), 2'd2, d); chk("R7 window", d, win_m(c));
      end
      bus_rd(8'(8'h44 + 8 * (p % 4)), 2'd2, d); chk("R7 window gap", d, 0);
    end

    // R6 cross case: core from one source, line from another
    bus_wr(8'h28, 2'd2, 32'hFFFFFFFF); en_m = '1;
    for (int s = 0; s < 32; s++) begin
      route_m[s] = '0; bus_wr(8'(s), 2'd0, 0);
    end
    route_m[3] = 8'h01; bus_wr(8'd3, 2'd0, 32'h01);
    route_m[9] = 8'h40; bus_wr(8'd9, 2'd0, 32'h40);
    irq_i = 32'h0000_0208;
    @(negedge clk_i);
    chk("R6 cross sources", 32'(irq_o), 32'h0004);
    irq_i = 32'h0000_0008;
    @(negedge clk_i);
    chk("R10 one edge later", 32'(irq_o), 32'h0000);

    // R8 illegal sizes and alignment
    irq_i = 32'h0000_0208;
    bus_wr(8'h00, 2'd2, 32'hFFFFFFFF);
    bus_rd(8'h00, 2'd0, d); chk("R8 word to route", d, 0);
    bus_wr(8'h2C, 2'd0, 32'hFF);
    bus_wr(8'h2C, 2'd1, 32'hFFFF);
    bus_wr(8'h2E, 2'd2, 32'hFFFFFFFF);
    bus_wr(8'h03, 2'd3, 32'hFF);
    bus_rd(8'h24, 2'd2, d); chk("R8 enable kept", d, en_m);
    bus_rd(8'h03, 2'd2, d); chk("R8 misaligned read", d, 0);
    bus_rd(8'h20, 2'd0, d); chk("R8 byte read of status", d, 0);
    bus_rd(8'h24, 2'd1, d); chk("R8 half read", d, 0);
    bus_rd(8'h03, 2'd0, d); chk("R8 route kept", d, 32'h01);
    @(negedge clk_i);
    chk("R8 outputs kept", 32'(irq_o), 32'(out_m()));

    // R9 ignored writes, zero reads
    bus_wr(8'h24, 2'd2, 32'h0);
    bus_wr(8'h20, 2'd2, 32'h0);
    bus_wr(8'h40, 2'd2, 32'h0);
    bus_wr(8'h30, 2'd2, 32'hFFFFFFFF);
    bus_rd(8'h24, 2'd2, d); chk("R9 enable kept", d, en_m);
    bus_rd(8'h40, 2'd2, d); chk("R9 window recomputed", d, win_m(0));
    bus_rd(8'h28, 2'd2, d); chk("R9 set reads zero", d, 0);
    bus_rd(8'h2C, 2'd2, d); chk("R9 clear reads zero", d, 0);
    @(negedge clk_i);
    chk("R9 outputs kept", 32'(irq_o), 32'h0004);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule